// File: doc/BRIEF.md
# Pixel Word Serializer with Path-Coded Frame Strobe

This block turns a stream of 14-bit pixel samples into one serial lane. It runs on the bit clock, which is sixteen times the pixel rate. Once per 16-cycle slot it takes one word from the pixel source. It then drives the word out most significant bit first. A low guard bit sits in front of the word and another low guard bit follows it, so a receiver whose clock wobbles slightly still sees all fourteen data bits.

Alongside the data the block drives a frame strobe. The strobe goes high together with the first data bit, so the receiver can find the start of each word. In correlated-double-sampling operation, pixels take turns between two sampling paths. The strobe width tells the receiver which path a pixel used, so a later stage can apply a per-path offset correction. In sample-and-hold operation there is only one path, and every pixel gets the long strobe. A third output toggles every bit-time and gives a half-rate clock for double-data-rate transmission.

The pixel source holds the word, its valid flag and the mode for the whole slot. Bit-time k of a slot means the k-th of the 16 bit-times, counted from 0.

Top module: `pix_lane_serializer`

## Requirements
- R1: After reset is released, the inputs are sampled on the first rising clock edge and then on every 16th edge after it, and at no other edge. Bit-time k of a sampled word appears on the outputs k+1 clock edges after the sampling edge.
- R2: In each slot, bit-times 0 and 15 drive the serial output low. Bit-times 1 to 14 carry data bits 13 down to 0, in that order.
- R3: The frame strobe goes high in bit-time 1, the same bit-time as data bit 13, and at no other bit-time.
- R4: In sample-and-hold mode (cds_mode=0), every valid pixel holds the strobe high during bit-times 1 to 6 and low from bit-time 7 (data bit 7) onward. That is three periods of the half-rate clock.
- R5: In correlated-double-sampling mode (cds_mode=1), the valid pixels alternate even, odd, even, odd, and the first pixel after reset is even. An even pixel holds the strobe high during bit-times 1 to 4, which is two clock periods, and the strobe falls at data bit 9. An odd pixel holds it high during bit-times 1 to 6.
- R6: If path_rst is high on a sampling edge, or on any edge after the previous sampling edge, the next sampled pixel is treated as even.
- R7: A pixel sampled in sample-and-hold mode does not advance the path alternation. The next correlated-double-sampling pixel takes the path that would have followed the last correlated-double-sampling pixel.
- R8: A slot sampled with pix_valid=0 sends all zeros with the strobe low for the whole slot, and it does not advance the path alternation.
- R9: bclk_o is high in the even bit-times of a slot and low in the odd ones.
- R10: While reset is held, and in the cycle after it, ser_o, frm_o and bclk_o are all low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Bit clock, 16 times the pixel rate |
| rst | input | 1 | Synchronous active-high reset |
| pix_data | input | 14 | Pixel sample, held for the whole slot |
| pix_valid | input | 1 | High when pix_data carries a real pixel |
| cds_mode | input | 1 | 1 for correlated double sampling, 0 for sample-and-hold |
| path_rst | input | 1 | Makes the next pixel even |
| ser_o | output | 1 | Serial data lane |
| frm_o | output | 1 | Frame strobe whose width encodes the path |
| bclk_o | output | 1 | Half-rate bit clock for double-data-rate transmission |

## Verification
The sample-and-hold runs use all-ones, alternating-bit, single-MSB and single-LSB words. Together they tell a correct bit order from a reversed or shifted one, and a dropped guard bit from a missing data bit. The bench changes pix_data in the middle of every slot, which shows whether a word is taken only on the sampling edge. The correlated-double-sampling runs check the alternation from reset, its freeze across sample-and-hold and invalid slots, and path resets given on the sampling edge and in the middle of a slot. These runs separate a wrong parity toggle from a wrong strobe width.

// File: rtl/pws_pkg.sv
package pws_pkg;

  typedef enum logic {
    PATH_EVEN = 1'b0,
    PATH_ODD  = 1'b1
  } path_e;

  typedef struct packed {
    logic vld;
    logic long_frm;
  } slot_info_t;

endpackage

// File: rtl/pws_slot_timer.sv
module pws_slot_timer #(
  parameter int SLOT_LEN = 16,
  localparam int CNT_W   = $clog2(SLOT_LEN)
) (
  input  logic             clk,
  input  logic             rst,
  output logic [CNT_W-1:0] cnt_o,
  output logic             load_o
);

  localparam logic [CNT_W-1:0] LAST = CNT_W'(SLOT_LEN - 1);

  logic [CNT_W-1:0] cnt_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      cnt_q <= LAST;
    end else if (cnt_q == LAST) begin
      cnt_q <= '0;
    end else begin
      cnt_q <= cnt_q + 1'b1;
    end
  end

  assign cnt_o  = cnt_q;
  assign load_o = (cnt_q == LAST);

  // R1
  wrap_after_load_chk: assert property (@(posedge clk) disable iff (rst)
    load_o |=> (cnt_q == '0));

endmodule

// File: rtl/pws_path_tracker.sv
module pws_path_tracker
  import pws_pkg::*;
(
  input  logic       clk,
  input  logic       rst,
  input  logic       load_i,
  input  logic       valid_i,
  input  logic       cds_i,
  input  logic       path_rst_i,
  output slot_info_t info_o
);

  path_e      par_q;
  logic       pend_q;
  slot_info_t info_q;
  logic       rst_req;
  path_e      eff_path;

  assign rst_req  = pend_q | path_rst_i;
  assign eff_path = rst_req ? PATH_EVEN : par_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      par_q  <= PATH_EVEN;
      pend_q <= 1'b0;
      info_q <= '0;
    end else if (load_i) begin
      info_q.vld      <= valid_i;
      info_q.long_frm <= ~cds_i | (eff_path == PATH_ODD);
      par_q           <= (cds_i & valid_i) ? path_e'(~eff_path) : eff_path;
      pend_q          <= 1'b0;
    end else if (path_rst_i) begin
      pend_q <= 1'b1;
    end
  end

  assign info_o = info_q;

  // R5
  cds_toggle_chk: assert property (@(posedge clk) disable iff (rst)
    (load_i && cds_i && valid_i && !rst_req) |=> (par_q != $past(par_q)));

  // R6
  path_reset_even_chk: assert property (@(posedge clk) disable iff (rst)
    (load_i && rst_req && cds_i && valid_i) |=> (par_q == PATH_ODD && !info_q.long_frm));

  // R7
  sh_freeze_chk: assert property (@(posedge clk) disable iff (rst)
    (load_i && !cds_i && !rst_req) |=> $stable(par_q));

  // R8
  idle_freeze_chk: assert property (@(posedge clk) disable iff (rst)
    (load_i && !valid_i && !rst_req) |=> $stable(par_q));

endmodule

// File: rtl/pws_lane_driver.sv
module pws_lane_driver
  import pws_pkg::*;
#(
  parameter int DATA_W   = 14,
  parameter int LONG_HI  = 6,
  parameter int SHORT_HI = 4,
  localparam int SLOT_LEN = DATA_W + 2,
  localparam int CNT_W    = $clog2(SLOT_LEN)
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              load_i,
  input  logic [CNT_W-1:0]  cnt_i,
  input  logic [DATA_W-1:0] data_i,
  input  logic              valid_i,
  input  slot_info_t        info_i,
  output logic              ser_o,
  output logic              frm_o,
  output logic              bclk_o
);

  localparam logic [CNT_W-1:0] FIRST_BT = CNT_W'(1);
  localparam logic [CNT_W-1:0] LONG_BT  = CNT_W'(LONG_HI);
  localparam logic [CNT_W-1:0] SHORT_BT = CNT_W'(SHORT_HI);

  logic [SLOT_LEN-1:0] sr_q;
  logic                ser_q, frm_q, bclk_q;
  logic [CNT_W-1:0]    hi_end;
  logic                frm_nxt;

  assign hi_end  = info_i.long_frm ? LONG_BT : SHORT_BT;
  assign frm_nxt = info_i.vld && (cnt_i >= FIRST_BT) && (cnt_i <= hi_end);

  always_ff @(posedge clk) begin
    if (rst) begin
      sr_q   <= '0;
      ser_q  <= 1'b0;
      frm_q  <= 1'b0;
      bclk_q <= 1'b0;
    end else begin
      ser_q  <= sr_q[SLOT_LEN-1];
      frm_q  <= frm_nxt;
      bclk_q <= ~cnt_i[0];
      if (load_i) begin
        sr_q <= valid_i ? {1'b0, data_i, 1'b0} : '0;
      end else begin
        sr_q <= {sr_q[SLOT_LEN-2:0], 1'b0};
      end
    end
  end

  assign ser_o  = ser_q;
  assign frm_o  = frm_q;
  assign bclk_o = bclk_q;

  // R2
  lead_guard_chk: assert property (@(posedge clk) disable iff (rst)
    (cnt_i == CNT_W'(1)) |-> !ser_o);

  // R2
  tail_guard_chk: assert property (@(posedge clk) disable iff (rst)
    (cnt_i == '0) |-> (!ser_o && !frm_o));

  // R3
  frame_rise_chk: assert property (@(posedge clk) disable iff (rst)
    $rose(frm_o) |-> (cnt_i == CNT_W'(2)));

  // R4
  frame_fall_chk: assert property (@(posedge clk) disable iff (rst)
    $fell(frm_o) |-> (cnt_i == CNT_W'(SHORT_HI + 2) || cnt_i == CNT_W'(LONG_HI + 2)));

endmodule

// File: rtl/pix_lane_serializer.sv
module pix_lane_serializer
  import pws_pkg::*;
#(
  parameter int DATA_W   = 14,
  parameter int LONG_HI  = 6,
  parameter int SHORT_HI = 4
) (
  input  logic              clk,
  input  logic              rst,
  input  logic [DATA_W-1:0] pix_data,
  input  logic              pix_valid,
  input  logic              cds_mode,
  input  logic              path_rst,
  output logic              ser_o,
  output logic              frm_o,
  output logic              bclk_o
);

  localparam int SLOT_LEN = DATA_W + 2;
  localparam int CNT_W    = $clog2(SLOT_LEN);

  logic [CNT_W-1:0] cnt;
  logic             load;
  slot_info_t       info;

  pws_slot_timer #(.SLOT_LEN(SLOT_LEN)) u_timer (
    .clk    (clk),
    .rst    (rst),
    .cnt_o  (cnt),
    .load_o (load)
  );

  pws_path_tracker u_path (
    .clk        (clk),
    .rst        (rst),
    .load_i     (load),
    .valid_i    (pix_valid),
    .cds_i      (cds_mode),
    .path_rst_i (path_rst),
    .info_o     (info)
  );

  pws_lane_driver #(
    .DATA_W   (DATA_W),
    .LONG_HI  (LONG_HI),
    .SHORT_HI (SHORT_HI)
  ) u_lane (
    .clk     (clk),
    .rst     (rst),
    .load_i  (load),
    .cnt_i   (cnt),
    .data_i  (pix_data),
    .valid_i (pix_valid),
    .info_i  (info),
    .ser_o   (ser_o),
    .frm_o   (frm_o),
    .bclk_o  (bclk_o)
  );

endmodule

// File: tb/sim_pix_lane_serializer.sv
`timescale 1ns/1ps
module sim_pix_lane_serializer;

  logic        clk = 1'b0;
  logic        rst;
  logic [13:0] pix_data;
  logic        pix_valid, cds_mode, path_rst;
  logic        ser_o, frm_o, bclk_o;

  int n_chk  = 0;
  int n_fail = 0;
  bit done   = 0;

  // bench model of the path alternation
  bit par_odd = 0;
  bit pend    = 0;

  localparam logic [14:0] FRM_LONG  = 15'b011111100000000;
  localparam logic [14:0] FRM_SHORT = 15'b011110000000000;
  localparam logic [14:0] BCLK_EXP  = 15'b101010101010101;

  always #2.5 clk = ~clk;

  pix_lane_serializer u0 (
    .clk (clk), .rst (rst), .pix_data (pix_data), .pix_valid (pix_valid),
    .cds_mode (cds_mode), .path_rst (path_rst),
    .ser_o (ser_o), .frm_o (frm_o), .bclk_o (bclk_o)
  );

  task automatic check(string req, logic [14:0] act, logic [14:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  // One slot: drives at the negedge before the sampling edge, returns at the
  // negedge before the next sampling edge. mid_rst pulses path_rst mid-slot.
  task automatic send_slot(logic [13:0] d, bit v, bit cds, bit prst_load,
                           bit mid_rst, string req);
    logic [14:0] s_act, f_act, b_act, s_exp, f_exp;
    bit odd, long_f;
    pix_data  = d;
    pix_valid = v;
    cds_mode  = cds;
    path_rst  = prst_load;
    odd       = (prst_load || pend) ? 1'b0 : par_odd;
    long_f    = !cds || odd;
    par_odd   = (cds && v) ? !odd : odd;
    pend      = 0;
    s_exp     = v ? {1'b0, d} : '0;
    f_exp     = v ? (long_f ? FRM_LONG : FRM_SHORT) : '0;
    for (int j = 1; j <= 16; j++) begin
      @(negedge clk);
      if (j == 1) begin
        path_rst = 1'b0;
        // R2: trailing guard of the previous slot (R10 right after reset)
        check("R2 trailing guard", {12'd0, ser_o, frm_o, bclk_o}, 15'd0);
      end else begin
        s_act[16-j] = ser_o;
        f_act[16-j] = frm_o;
        b_act[16-j] = bclk_o;
      end
      // R1: the word must be taken only at the sampling edge
      if (j == 3) pix_data = ~d;
      if (mid_rst && j == 5) begin path_rst = 1'b1; pend = 1; end
      if (mid_rst && j == 6) path_rst = 1'b0;
    end
    check({req, " data"}, s_act, s_exp);
    check({req, " frame"}, f_act, f_exp);
    check("R9 bclk", b_act, BCLK_EXP);
  endtask

  task automatic t_reset();
    rst = 1'b1; pix_data = '0; pix_valid = 0; cds_mode = 0; path_rst = 0;
    repeat (4) @(negedge clk);
    // R10
    check("R10 reset outputs", {12'd0, ser_o, frm_o, bclk_o}, 15'd0);
    rst = 1'b0;
  endtask

  task automatic t_sh_patterns();
    // R1 R2 R3 R4
    send_slot(14'h3FFF, 1, 0, 0, 0, "R4");
    send_slot(14'h2AAA, 1, 0, 0, 0, "R2");
    send_slot(14'h1555, 1, 0, 0, 0, "R2");
    send_slot(14'h2000, 1, 0, 0, 0, "R3");
    send_slot(14'h0001, 1, 0, 0, 0, "R1");
  endtask

  task automatic t_cds_alternation();
    // R5: first pixel after reset even, then odd, even, odd
    send_slot(14'h1234, 1, 1, 0, 0, "R5 even");
    send_slot(14'h0F0F, 1, 1, 0, 0, "R5 odd");
    send_slot(14'h3C3C, 1, 1, 0, 0, "R5 even");
    send_slot(14'h0ABC, 1, 1, 0, 0, "R5 odd");
  endtask

  task automatic t_sh_freeze();
    // R7: even, two S/H pixels, next CDS pixel odd
    send_slot(14'h0111, 1, 1, 0, 0, "R7 even");
    send_slot(14'h0222, 1, 0, 0, 0, "R7 sh");
    send_slot(14'h0333, 1, 0, 0, 0, "R7 sh");
    send_slot(14'h0444, 1, 1, 0, 0, "R7 odd");
  endtask

  task automatic t_invalid();
    // R8: idle slot all zero, no parity step
    send_slot(14'h2468, 1, 1, 0, 0, "R8 even");
    send_slot(14'h3FFF, 0, 1, 0, 0, "R8 idle");
    send_slot(14'h1357, 1, 1, 0, 0, "R8 odd");
  endtask

  task automatic t_path_reset();
    // R6: reset on the sampling edge, then reset in mid-slot
    send_slot(14'h0A0A, 1, 1, 0, 0, "R6 even");
    send_slot(14'h0B0B, 1, 1, 1, 0, "R6 forced even");
    send_slot(14'h0C0C, 1, 1, 0, 1, "R6 odd");
    send_slot(14'h0D0D, 1, 1, 0, 0, "R6 pending even");
    send_slot(14'h0E0E, 1, 1, 0, 0, "R6 odd after");
  endtask

  initial begin
    t_reset();
    t_sh_patterns();
    t_cds_alternation();
    t_sh_freeze();
    t_invalid();
    t_path_reset();
    send_slot(14'h0000, 0, 0, 0, 0, "R8 final idle");
    if (!done) begin
      done = 1;
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
    end
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      done = 1;
      n_chk++;
      n_fail++;
      $display("FAIL watchdog actual=running expected=finished");
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
    end
  end

endmodule